// File: doc/BRIEF.md
# NAND Page ECC Generator

This block watches the byte stream on a NAND controller's data path and builds a three-byte Hamming-style check code for every 256-byte chunk that passes while it is armed. Each code holds sixteen line-parity bits, one odd/even pair per address bit of a byte inside the chunk, and six column-parity bits taken over bit groups within each byte. Chunks follow one another without software help: after every 256th counted byte the finished code is filed and a fresh chunk begins. Up to eight codes are kept, which covers a 2048-byte page.

Software steers the engine through a two-bit field of the controller's mode control byte. To arm it, software writes clear, then idle, then accumulate. After the page has moved, it writes idle, then drain, and reads the codes back one byte per read strobe through the shared data port. Within each chunk the two line-parity bytes come out swapped. Error correction stays in software, which compares these codes with the ones stored in the spare area.

Top module: `nand_ecc_gen`

## Requirements
- R1: The engine mode is bits 6:5 of `mode_ctl`: 00 idle, 01 accumulate, 10 drain, 11 clear. Bit 0 is the command-latch flag and bit 1 the address-latch flag. The other bits of `mode_ctl` have no effect.
- R2: While the mode is clear, at each clock edge the stored codes, the chunk count, the read pointer, the byte counter and the partial parity are all discarded. After reset, and on the first cycle after a clear, `rd_data` reads 0xFF.
- R3: A byte counts toward a code only when `byte_valid` is high, the mode is accumulate, and both latch flags are low. Bytes moved in idle mode, or with either latch flag set, do not change any code.
- R4: Code byte 0 carries the line parity for byte-address bits 0..3, and code byte 1 carries it for bits 4..7. For address bit j, bit 2j (mod 8) is the inverted XOR of the byte parities of all bytes whose address bit j is 0. Bit 2j+1 is the same over the bytes whose address bit j is 1.
- R5: Code byte 2 holds the inverted column parities over the whole chunk. Bit 2 covers data bits {0,2,4,6}, bit 3 covers {1,3,5,7}, bit 4 covers {0,1,4,5}, bit 5 covers {2,3,6,7}, bit 6 covers {0..3} and bit 7 covers {4..7}. Bits 1:0 are always 1, so a chunk of all 0xFF yields FF FF FF.
- R6: After every 256th counted byte the code is stored and a new chunk starts with empty parity. Each chunk's code depends only on its own 256 bytes, even if the stream pauses between bytes.
- R7: In drain mode, `rd_data` presents the current code byte, and each `rd_strobe` cycle advances to the next one. Chunks come out in the order they were stored; within a chunk the order is byte 1, byte 0, byte 2. A strobe in any other mode does not move the read position.
- R8: At most 8 codes are kept, and further finished chunks are dropped. Reads beyond the last stored code byte return 0xFF.
- R9: A chunk with fewer than 256 counted bytes produces no stored code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_ctl | input | 8 | Mode control byte: ECC mode in bits 6:5, command-latch flag bit 0, address-latch flag bit 1 |
| byte_valid | input | 1 | A data byte moves across the data path this cycle |
| byte_data | input | 8 | The data byte being moved |
| rd_strobe | input | 1 | Data-port read of a code byte; advances the read position in drain mode |
| rd_data | output | 8 | Code byte at the current read position, or 0xFF past the stored codes |

## Verification
Any wrong internal state shows up only at `rd_data`, and only during the drain phase. That can be thousands of cycles after the byte that caused it. A slip in the byte counter moves a chunk boundary, so the codes of that chunk and of every later chunk come out wrong. A parity bit that was misrouted corrupts exactly one bit of one code byte. A read pointer that moves when it should not shifts every later read by one position. For these reasons the bench checks every code byte against a reference computed from the data. It uses single-bit, all-0xFF and random chunks, paused and noisy streams, overflow past eight chunks, and clears in the middle of a chunk.

// File: rtl/nand_ecc_pkg.sv
`timescale 1ns/1ps
package nand_ecc_pkg;

    // address bits of a byte within one chunk (256 bytes)
    localparam int CHUNK_AW    = 8;
    localparam int COL_BITS    = 6;
    localparam int MODE_LSB    = 5;
    localparam int CMD_LAT_BIT = 0;
    localparam int ADR_LAT_BIT = 1;
    localparam logic [7:0] ERASED_BYTE = 8'hFF;

    typedef enum logic [1:0] {
        ECC_IDLE  = 2'b00,
        ECC_ACCUM = 2'b01,
        ECC_DRAIN = 2'b10,
        ECC_CLEAR = 2'b11
    } ecc_mode_e;

    typedef struct packed {
        logic [7:0] col;      // code byte 2
        logic [7:0] line_hi;  // code byte 1
        logic [7:0] line_lo;  // code byte 0
    } ecc_code_t;

    // column parity contribution of one data byte
    function automatic logic [COL_BITS-1:0] col_step(input logic [7:0] d);
        logic [COL_BITS-1:0] c;
        c[0] = d[0] ^ d[2] ^ d[4] ^ d[6];
        c[1] = d[1] ^ d[3] ^ d[5] ^ d[7];
        c[2] = d[0] ^ d[1] ^ d[4] ^ d[5];
        c[3] = d[2] ^ d[3] ^ d[6] ^ d[7];
        c[4] = ^d[3:0];
        c[5] = ^d[7:4];
        return c;
    endfunction

    // interleave line parity pairs and invert into the stored layout
    function automatic ecc_code_t pack_code(input logic [CHUNK_AW-1:0] odd,
                                            input logic [CHUNK_AW-1:0] even,
                                            input logic [COL_BITS-1:0] col);
        logic [2*CHUNK_AW-1:0] lp;
        ecc_code_t r;
        for (int j = 0; j < CHUNK_AW; j++) begin
            lp[2*j]   = ~even[j];
            lp[2*j+1] = ~odd[j];
        end
        r.line_lo = lp[7:0];
        r.line_hi = lp[15:8];
        r.col     = {~col, 2'b11};
        return r;
    endfunction

endpackage

// File: rtl/nand_ecc_mode_dec.sv
`timescale 1ns/1ps
module nand_ecc_mode_dec
    import nand_ecc_pkg::*;
(
    input  logic [7:0] mode_ctl,
    output logic       clear,
    output logic       accum_en,
    output logic       drain_en,
    output logic       latch_busy
);

    ecc_mode_e mode;

    always_comb begin
        mode       = ecc_mode_e'(mode_ctl[MODE_LSB +: 2]);
        clear      = 1'b0;
        accum_en   = 1'b0;
        drain_en   = 1'b0;
        latch_busy = mode_ctl[CMD_LAT_BIT] | mode_ctl[ADR_LAT_BIT];
        unique case (mode)
            ECC_CLEAR: clear    = 1'b1;
            ECC_ACCUM: accum_en = 1'b1;
            ECC_DRAIN: drain_en = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/nand_ecc_parity.sv
`timescale 1ns/1ps
module nand_ecc_parity
    import nand_ecc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       take,
    input  logic [7:0] din,
    output logic       code_done,
    output ecc_code_t  code_out
);

    typedef struct packed {
        logic [CHUNK_AW-1:0] cnt;
        logic [CHUNK_AW-1:0] odd;
        logic [CHUNK_AW-1:0] even;
        logic [COL_BITS-1:0] col;
        logic                done;
        ecc_code_t           code;
    } par_state_t;

    par_state_t st_d, st_q;

    always_comb begin
        logic                bp;
        logic [CHUNK_AW-1:0] odd_n;
        logic [CHUNK_AW-1:0] even_n;
        logic [COL_BITS-1:0] col_n;

        st_d      = st_q;
        st_d.done = 1'b0;

        bp     = ^din;
        odd_n  = st_q.odd;
        even_n = st_q.even;
        col_n  = st_q.col ^ col_step(din);
        for (int j = 0; j < CHUNK_AW; j++) begin
            if (st_q.cnt[j]) odd_n[j]  = odd_n[j] ^ bp;
            else             even_n[j] = even_n[j] ^ bp;
        end

        if (clear) begin
            st_d = '0;
        end else if (take) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (&st_q.cnt) begin
                st_d.done = 1'b1;
                st_d.code = pack_code(odd_n, even_n, col_n);
                st_d.odd  = '0;
                st_d.even = '0;
                st_d.col  = '0;
            end else begin
                st_d.odd  = odd_n;
                st_d.even = even_n;
                st_d.col  = col_n;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign code_done = st_q.done;
    assign code_out  = st_q.code;

    // R6
    chunk_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !clear && (&st_q.cnt)) |=> (code_done && st_q.cnt == '0));

    // R2
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (st_q.cnt == '0 && !code_done && st_q.col == '0));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !clear) |=> $stable(st_q.cnt));

endmodule

// File: rtl/nand_ecc_store.sv
`timescale 1ns/1ps
module nand_ecc_store
    import nand_ecc_pkg::*;
#(
    parameter int MAX_CHUNKS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       code_done,
    input  ecc_code_t  code_in,
    input  logic       drain_step,
    output logic [7:0] rd_byte
);

    localparam int SLOT_BYTES  = 3;
    localparam int TOTAL_BYTES = SLOT_BYTES * MAX_CHUNKS;
    localparam int CNT_W       = $clog2(MAX_CHUNKS + 1);
    localparam int PTR_W       = $clog2(TOTAL_BYTES + 1);

    typedef struct packed {
        ecc_code_t [MAX_CHUNKS-1:0] slot;
        logic [CNT_W-1:0]           fill;
        logic [PTR_W-1:0]           ptr;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            for (int c = 0; c < MAX_CHUNKS; c++) st_d.slot[c] = '1;
            st_d.fill = '0;
            st_d.ptr  = '0;
        end else begin
            if (code_done && st_q.fill < CNT_W'(MAX_CHUNKS)) begin
                for (int c = 0; c < MAX_CHUNKS; c++) begin
                    if (CNT_W'(c) == st_q.fill) st_d.slot[c] = code_in;
                end
                st_d.fill = st_q.fill + 1'b1;
            end
            if (drain_step && st_q.ptr < PTR_W'(TOTAL_BYTES)) begin
                st_d.ptr = st_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.slot <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    // read order within a chunk: byte 1, byte 0, byte 2
    always_comb begin
        rd_byte = ERASED_BYTE;
        for (int c = 0; c < MAX_CHUNKS; c++) begin
            for (int k = 0; k < SLOT_BYTES; k++) begin
                if (st_q.ptr == PTR_W'(SLOT_BYTES * c + k) && CNT_W'(c) < st_q.fill) begin
                    if (k == 0)      rd_byte = st_q.slot[c].line_hi;
                    else if (k == 1) rd_byte = st_q.slot[c].line_lo;
                    else             rd_byte = st_q.slot[c].col;
                end
            end
        end
    end

    // R7
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!drain_step && !clear) |=> $stable(st_q.ptr));

    // R8
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fill == CNT_W'(MAX_CHUNKS) && !clear) |=> (st_q.fill == CNT_W'(MAX_CHUNKS)));

    // R2
    clear_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (rd_byte == ERASED_BYTE));

    // R8
    past_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ptr >= PTR_W'(TOTAL_BYTES)) |-> (rd_byte == ERASED_BYTE));

endmodule

// File: rtl/nand_ecc_gen.sv
`timescale 1ns/1ps
module nand_ecc_gen
    import nand_ecc_pkg::*;
#(
    parameter int MAX_CHUNKS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] mode_ctl,
    input  logic       byte_valid,
    input  logic [7:0] byte_data,
    input  logic       rd_strobe,
    output logic [7:0] rd_data
);

    logic      clear;
    logic      accum_en;
    logic      drain_en;
    logic      latch_busy;
    logic      take;
    logic      drain_step;
    logic      code_done;
    ecc_code_t code;

    nand_ecc_mode_dec u_dec (
        .mode_ctl   (mode_ctl),
        .clear      (clear),
        .accum_en   (accum_en),
        .drain_en   (drain_en),
        .latch_busy (latch_busy)
    );

    assign take       = byte_valid & accum_en & ~latch_busy;
    assign drain_step = rd_strobe & drain_en;

    nand_ecc_parity u_par (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .take      (take),
        .din       (byte_data),
        .code_done (code_done),
        .code_out  (code)
    );

    nand_ecc_store #(.MAX_CHUNKS(MAX_CHUNKS)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .code_done  (code_done),
        .code_in    (code),
        .drain_step (drain_step),
        .rd_byte    (rd_data)
    );

    // R1
    mode_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({clear, accum_en, drain_en}));

endmodule

// File: tb/nand_ecc_gen_bench.sv
`timescale 1ns/1ps
module nand_ecc_gen_bench;

    localparam logic [1:0] M_IDLE = 2'b00, M_ACC = 2'b01, M_DRN = 2'b10, M_CLR = 2'b11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] mode_ctl = 8'h00;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       rd_strobe = 1'b0;
    logic [7:0] rd_data;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 0;

    logic [7:0] cbuf [256];
    logic [7:0] exp_q [$];

    nand_ecc_gen #(.MAX_CHUNKS(8)) u_nand_ecc_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_ctl   (mode_ctl),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .rd_strobe  (rd_strobe),
        .rd_data    (rd_data)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    // mode field bits 6:5, latch flags bits 1:0, other bits random (R1)
    task automatic set_ctl(input logic [1:0] m, input bit cl = 0, input bit al = 0);
        mode_ctl = {1'($urandom), m, 3'($urandom), al, cl};
        @(negedge clk);
    endtask

    // reference code from R4/R5, pushed in readout order (R7)
    task automatic add_expected();
        logic [7:0] odd, even;
        logic [5:0] col;
        logic [7:0] b0, b1, b2;
        odd = '0; even = '0; col = '0;
        for (int i = 0; i < 256; i++) begin
            logic [7:0] d;
            logic bp;
            d  = cbuf[i];
            bp = ^d;
            for (int j = 0; j < 8; j++) begin
                if (i[j]) odd[j] = odd[j] ^ bp;
                else      even[j] = even[j] ^ bp;
            end
            col[0] = col[0] ^ d[0] ^ d[2] ^ d[4] ^ d[6];
            col[1] = col[1] ^ d[1] ^ d[3] ^ d[5] ^ d[7];
            col[2] = col[2] ^ d[0] ^ d[1] ^ d[4] ^ d[5];
            col[3] = col[3] ^ d[2] ^ d[3] ^ d[6] ^ d[7];
            col[4] = col[4] ^ (^d[3:0]);
            col[5] = col[5] ^ (^d[7:4]);
        end
        for (int j = 0; j < 4; j++) begin
            b0[2*j]   = ~even[j];
            b0[2*j+1] = ~odd[j];
            b1[2*j]   = ~even[j+4];
            b1[2*j+1] = ~odd[j+4];
        end
        b2 = {~col, 2'b11};
        exp_q.push_back(b1);
        exp_q.push_back(b0);
        exp_q.push_back(b2);
    endtask

    task automatic fill_const(input logic [7:0] v);
        for (int i = 0; i < 256; i++) cbuf[i] = v;
    endtask

    task automatic fill_rand();
        for (int i = 0; i < 256; i++) cbuf[i] = 8'($urandom);
    endtask

    // stream n bytes of cbuf in accumulate mode; optional gaps and ignored noise bytes (R3)
    task automatic stream(input int n, input int gap_pct, input bit noise);
        for (int i = 0; i < n; i++) begin
            if (gap_pct > 0 && $urandom_range(99) < gap_pct) begin
                byte_valid = 1'b0;
                @(negedge clk);
            end
            if (noise && $urandom_range(3) == 0) begin
                mode_ctl[1:0] = $urandom_range(1) ? 2'b01 : 2'b10;
                byte_data  = 8'($urandom);
                byte_valid = 1'b1;
                @(negedge clk);
                mode_ctl[1:0] = 2'b00;
            end
            if (noise && $urandom_range(5) == 0) begin
                mode_ctl[6:5] = M_IDLE;
                byte_data  = 8'($urandom);
                byte_valid = 1'b1;
                @(negedge clk);
                mode_ctl[6:5] = M_ACC;
            end
            byte_data  = cbuf[i];
            byte_valid = 1'b1;
            @(negedge clk);
        end
        byte_valid = 1'b0;
    endtask

    task automatic arm();
        exp_q.delete();
        set_ctl(M_CLR);
        set_ctl(M_IDLE);
        set_ctl(M_ACC);
    endtask

    task automatic enter_drain();
        set_ctl(M_IDLE);
        set_ctl(M_DRN);
    endtask

    task automatic drain_check(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            logic [7:0] e;
            e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hFF;
            chk(req, rd_data, e);
            rd_strobe = 1'b1;
            @(negedge clk);
            rd_strobe = 1'b0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired before test end");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: reset state reads erased
        chk("R2 reset", rd_data, 8'hFF);

        // R5: all-0xFF chunk gives FF FF FF, then past end R8
        arm();
        fill_const(8'hFF);
        stream(256, 0, 0);
        add_expected();
        enter_drain();
        drain_check(4, "R5 all-ff");

        // R4: single low bit at byte 5
        arm();
        fill_const(8'hFF);
        cbuf[5] = 8'hFE;
        stream(256, 0, 0);
        add_expected();
        enter_drain();
        drain_check(3, "R4 single-bit");

        // R4: single high bit set in zero chunk at byte 0xA3
        arm();
        fill_const(8'h00);
        cbuf[8'hA3] = 8'h40;
        stream(256, 0, 0);
        add_expected();
        enter_drain();
        drain_check(3, "R4 high-address");

        // R6 / R7: two random chunks with gaps; strobes outside drain ignored
        arm();
        fill_rand(); stream(256, 25, 0); add_expected();
        fill_rand(); stream(256, 25, 0); add_expected();
        rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0;
        set_ctl(M_IDLE);
        rd_strobe = 1'b1; @(negedge clk); @(negedge clk); rd_strobe = 1'b0;
        set_ctl(M_DRN);
        drain_check(7, "R7 two-chunk order");

        // R3: noise bytes with latch flags or in idle mode are not counted
        arm();
        fill_rand(); stream(256, 10, 1); add_expected();
        fill_rand(); stream(256, 0, 1); add_expected();
        enter_drain();
        drain_check(6, "R3 noise ignored");

        // R9: partial chunk not stored
        arm();
        fill_rand(); stream(100, 0, 0);
        enter_drain();
        drain_check(2, "R9 partial");

        // R2: clear mid-chunk drops partial parity
        arm();
        fill_rand(); stream(100, 0, 0);
        set_ctl(M_CLR);
        set_ctl(M_IDLE);
        set_ctl(M_ACC);
        fill_rand(); stream(256, 5, 0); add_expected();
        enter_drain();
        drain_check(3, "R2 mid-chunk clear");

        // R8: nine chunks, only eight kept
        arm();
        for (int c = 0; c < 9; c++) begin
            fill_rand();
            stream(256, 0, 0);
            if (c < 8) add_expected();
        end
        enter_drain();
        drain_check(27, "R8 overflow");

        // R2: clear during drain resets pointer and codes
        arm();
        fill_rand(); stream(256, 0, 0); add_expected();
        enter_drain();
        drain_check(1, "R7 first byte");
        set_ctl(M_CLR);
        set_ctl(M_DRN);
        exp_q.delete();
        drain_check(3, "R2 clear in drain");

        // R1: latch flag high with the clear field still clears
        arm();
        fill_const(8'h5A); stream(256, 0, 0);
        set_ctl(M_CLR, 1, 1);
        set_ctl(M_DRN);
        drain_check(1, "R1 clear with latch bits");

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule